// File: doc/BRIEF.md
# Paged Flash Cartridge Glue

This block joins a host computer's cartridge slot to a parallel NOR flash memory. From the slot's select strobe, its read/write line and its bus clock it forms the three active-low flash strobes: chip enable, output enable and write enable. The slot select strobe is not clock-qualified by the host. It may glitch, or stay low, outside real accesses. The block therefore lets the chip enable through only during the high phase of the bus clock.

The block also holds a small write-only page register at one fixed host address. The register drives the upper flash address lines, so several 16 KB flash images can be swapped into the host's single 16 KB window. All logic runs on a fast core clock that samples the slot pins. The strobes pass through combinationally. The page register captures the last address, data and direction seen during the high bus phase and commits them at the falling bus-clock edge, which is when host write data is reliably valid.

Top module: `cart_flash_glue`

## Requirements
- R1: `flash_ce_n` is low exactly when `slot_oe_n` is low and `slot_phi` is high, within the same cycle and with no register delay.
- R2: `flash_oe_n` is low exactly when `host_rnw` is 1 (host read).
- R3: `flash_we_n` is low exactly when `host_rnw` is 0 (host write).
- R4: `flash_ce_n` stays high during every cycle in which `slot_phi` is low, even when `slot_oe_n` falls or toggles during that low phase.
- R5: Reset (`rst_n` low, asynchronous) clears the page register to 0, so `flash_addr[16:15]` reads 0 after reset.
- R6: When the last core-clock sample taken with `slot_phi` high shows `host_addr` equal to 16'hFC80 and `host_rnw` 0, the page register loads `host_data[1:0]` at the first core-clock edge that samples `slot_phi` low. From that edge on, `flash_addr[16:15]` equals the loaded value, with `host_data[0]` on bit 15.
- R7: A write to any other address, or a read of 16'hFC80, leaves `flash_addr[16:15]` unchanged.
- R8: The page value persists across any number of later bus cycles until the next qualifying write.
- R9: `flash_addr[13:0]` equals `host_addr[13:0]` and `flash_addr[14]` is 0.
- R10: If `host_data` changes during the high phase of a page write, the value present at the last high-phase sample is the one stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock that samples the slot signals |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 16 | Host address bus |
| host_data | input | 8 | Host data bus |
| host_rnw | input | 1 | Host direction, 1 = read, 0 = write |
| slot_oe_n | input | 1 | Slot select strobe, active low, not clock-qualified |
| slot_phi | input | 1 | Slot bus clock |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_we_n | output | 1 | Flash write enable, active low |
| flash_addr | output | 17 | Flash address: window bits, zero gap bit, page bits |

## Verification
The three strobes respond in the same cycle as their inputs change, so they are compared at the falling core-clock edge that follows each input update. A page write appears on `flash_addr[16:15]` only at the first rising core-clock edge that samples `slot_phi` low. The bench model applies the load at that same edge, and the directed checks sample half a period later, never while the bus clock is still high. Glitches on the select strobe during the low phase are placed between samples that are each checked against the phase rule.

// File: rtl/cart_glue_pkg.sv
package cart_glue_pkg;

   // Snapshot of the host bus taken while the bus clock is high
   typedef struct packed {
      logic       hit;    // register address decoded with write direction
      logic [7:0] data;   // full data byte, page bits picked later
   } bus_snap_t;

   function automatic logic addr_match(input logic [15:0] a,
                                       input logic [15:0] ref_a,
                                       input logic [15:0] mask);
      return ((a ^ ref_a) & mask) == 16'h0000;
   endfunction

endpackage

// File: rtl/cart_strobe_gen.sv
module cart_strobe_gen #(
   parameter bit QUALIFY_CE = 1'b1
) (
   input  logic slot_oe_n,
   input  logic slot_phi,
   input  logic host_rnw,
   output logic ce_n,
   output logic oe_n,
   output logic we_n
);

   generate
      if (QUALIFY_CE) begin : g_ce_qual
         // enable only during the high clock phase
         assign ce_n = slot_oe_n | ~slot_phi;
      end else begin : g_ce_raw
         assign ce_n = slot_oe_n;
      end
   endgenerate

   assign oe_n = ~host_rnw;
   assign we_n =  host_rnw;

endmodule

// File: rtl/cart_page_reg.sv
module cart_page_reg
   import cart_glue_pkg::*;
#(
   parameter int          ADDR_W   = 16,
   parameter int          DATA_W   = 8,
   parameter int          PAGE_W   = 2,
   parameter logic [15:0] REG_ADDR = 16'hFC80,
   parameter logic [15:0] REG_MASK = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_data,
   input  logic              host_rnw,
   input  logic              slot_phi,
   output logic [PAGE_W-1:0] page
);

   bus_snap_t   snap;
   logic        phi_q;
   logic        phi_fall;
   logic [7:0]  data_ext;

   generate
      if (DATA_W >= 8) begin : g_data_trim
         assign data_ext = host_data[7:0];
      end else begin : g_data_pad
         assign data_ext = {{(8-DATA_W){1'b0}}, host_data};
      end
   endgenerate

   // keep the most recent high-phase view of the bus
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap  <= '0;
         phi_q <= 1'b0;
      end else begin
         phi_q <= slot_phi;
         if (slot_phi) begin
            snap.hit  <= addr_match(host_addr[15:0], REG_ADDR, REG_MASK) & ~host_rnw;
            snap.data <= data_ext;
         end
      end
   end

   assign phi_fall = phi_q & ~slot_phi;

   // one flop per page bit, each committed at the falling bus edge
   for (genvar i = 0; i < PAGE_W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            page[i] <= 1'b0;
         end else if (phi_fall && snap.hit) begin
            page[i] <= snap.data[i];
         end
      end
   end

endmodule

// File: rtl/cart_addr_map.sv
module cart_addr_map #(
   parameter int ADDR_W   = 16,
   parameter int WIN_W    = 14,
   parameter int PAGE_W   = 2,
   parameter int PAGE_LSB = 15,
   localparam int FA_W    = PAGE_LSB + PAGE_W,
   localparam int GAP_W   = PAGE_LSB - WIN_W
) (
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [PAGE_W-1:0] page,
   output logic [FA_W-1:0]   flash_addr
);

   assign flash_addr[WIN_W-1:0]           = host_addr[WIN_W-1:0];
   assign flash_addr[FA_W-1:PAGE_LSB]     = page;

   generate
      if (GAP_W > 0) begin : g_gap
         assign flash_addr[PAGE_LSB-1:WIN_W] = '0;
      end
   endgenerate

endmodule

// File: rtl/cart_flash_glue.sv
module cart_flash_glue #(
   parameter int          ADDR_W     = 16,
   parameter int          DATA_W     = 8,
   parameter int          WIN_W      = 14,
   parameter int          PAGE_W     = 2,
   parameter int          PAGE_LSB   = 15,
   parameter logic [15:0] REG_ADDR   = 16'hFC80,
   parameter logic [15:0] REG_MASK   = 16'hFFFF,
   parameter bit          QUALIFY_CE = 1'b1,
   localparam int         FA_W       = PAGE_LSB + PAGE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_data,
   input  logic              host_rnw,
   input  logic              slot_oe_n,
   input  logic              slot_phi,
   output logic              flash_ce_n,
   output logic              flash_oe_n,
   output logic              flash_we_n,
   output logic [FA_W-1:0]   flash_addr
);

   // elaboration-time parameter checks
   if (ADDR_W != 16) begin : g_bad_addr
      $error("cart_flash_glue: ADDR_W must be 16");
   end
   if (WIN_W >= ADDR_W || WIN_W < 1) begin : g_bad_win
      $error("cart_flash_glue: WIN_W out of range");
   end
   if (PAGE_LSB < WIN_W) begin : g_bad_lsb
      $error("cart_flash_glue: page bits overlap the window");
   end
   if (PAGE_W < 1 || PAGE_W > DATA_W || PAGE_W > 8) begin : g_bad_page
      $error("cart_flash_glue: PAGE_W out of range");
   end

   logic [PAGE_W-1:0] page;

   cart_strobe_gen #(
      .QUALIFY_CE (QUALIFY_CE)
   ) u_strobe (
      .slot_oe_n (slot_oe_n),
      .slot_phi  (slot_phi),
      .host_rnw  (host_rnw),
      .ce_n      (flash_ce_n),
      .oe_n      (flash_oe_n),
      .we_n      (flash_we_n)
   );

   cart_page_reg #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .PAGE_W   (PAGE_W),
      .REG_ADDR (REG_ADDR),
      .REG_MASK (REG_MASK)
   ) u_page (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_addr (host_addr),
      .host_data (host_data),
      .host_rnw  (host_rnw),
      .slot_phi  (slot_phi),
      .page      (page)
   );

   cart_addr_map #(
      .ADDR_W   (ADDR_W),
      .WIN_W    (WIN_W),
      .PAGE_W   (PAGE_W),
      .PAGE_LSB (PAGE_LSB)
   ) u_map (
      .host_addr  (host_addr),
      .page       (page),
      .flash_addr (flash_addr)
   );

endmodule

// File: rtl/cart_flash_glue_chk.sv
module cart_flash_glue_chk #(
   parameter int          ADDR_W   = 16,
   parameter int          DATA_W   = 8,
   parameter int          PAGE_W   = 2,
   parameter int          PAGE_LSB = 15,
   parameter logic [15:0] REG_ADDR = 16'hFC80,
   localparam int         FA_W     = PAGE_LSB + PAGE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] host_addr,
   input logic [DATA_W-1:0] host_data,
   input logic              host_rnw,
   input logic              slot_oe_n,
   input logic              slot_phi,
   input logic              flash_ce_n,
   input logic              flash_oe_n,
   input logic              flash_we_n,
   input logic [FA_W-1:0]   flash_addr
);

   assert_ce_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_phi |-> flash_ce_n);

   assert_ce_active_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_phi && !slot_oe_n) |-> !flash_ce_n);

   assert_read_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      host_rnw |-> (!flash_oe_n && flash_we_n));

   assert_write_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rnw |-> (!flash_we_n && flash_oe_n));

   assert_page_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_phi || !$past(slot_phi)) |=> $stable(flash_addr[FA_W-1:PAGE_LSB]));

   assert_page_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(slot_phi) && !slot_phi &&
       $past(host_addr) == REG_ADDR && !$past(host_rnw))
      |=> flash_addr[FA_W-1:PAGE_LSB] == $past(host_data[PAGE_W-1:0], 2));

endmodule

bind cart_flash_glue cart_flash_glue_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .PAGE_W   (PAGE_W),
   .PAGE_LSB (PAGE_LSB),
   .REG_ADDR (REG_ADDR)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_addr  (host_addr),
   .host_data  (host_data),
   .host_rnw   (host_rnw),
   .slot_oe_n  (slot_oe_n),
   .slot_phi   (slot_phi),
   .flash_ce_n (flash_ce_n),
   .flash_oe_n (flash_oe_n),
   .flash_we_n (flash_we_n),
   .flash_addr (flash_addr)
);

// File: tb/sim_cart_flash_glue.sv
`timescale 1ns/1ps
module sim_cart_flash_glue;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] host_addr = 16'h0000;
   logic [7:0]  host_data = 8'h00;
   logic        host_rnw = 1'b1;
   logic        slot_oe_n = 1'b1;
   logic        slot_phi = 1'b0;
   logic        flash_ce_n, flash_oe_n, flash_we_n;
   logic [16:0] flash_addr;

   always #2.5 clk = ~clk;   // 200 MHz

   cart_flash_glue u0 (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_data(host_data),
      .host_rnw(host_rnw), .slot_oe_n(slot_oe_n), .slot_phi(slot_phi),
      .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n),
      .flash_addr(flash_addr)
   );

   // behavioural reference: remember last high-phase bus, apply on first low sample
   int unsigned m_page = 0;
   bit          m_prev_hi = 0;
   int          m_last_addr = -1;
   int          m_last_rnw = 1;
   int unsigned m_last_data = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_page = 0; m_prev_hi = 0; m_last_addr = -1; m_last_rnw = 1; m_last_data = 0;
      end else begin
         if (slot_phi) begin
            m_last_addr = host_addr; m_last_rnw = host_rnw; m_last_data = host_data % 4;
         end else if (m_prev_hi && m_last_addr == 'hFC80 && m_last_rnw == 0) begin
            m_page = m_last_data;
         end
         m_prev_hi = slot_phi;
      end
   end

   // cycle-by-cycle comparison
   int auto_chk = 0, auto_fail = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         automatic bit exp_ce = !(slot_phi && !slot_oe_n);
         automatic logic [16:0] exp_a = {m_page[1:0], 1'b0, host_addr[13:0]};
         auto_chk++;
         if (flash_ce_n !== exp_ce) begin
            auto_fail++; $display("FAIL R1/R4 ce_n act=%b exp=%b t=%0t", flash_ce_n, exp_ce, $time);
         end
         if (flash_oe_n !== !host_rnw || flash_we_n !== host_rnw) begin
            auto_fail++; $display("FAIL R2/R3 oe_n/we_n act=%b%b exp=%b%b", flash_oe_n, flash_we_n, !host_rnw, host_rnw);
         end
         if (flash_addr !== exp_a) begin
            auto_fail++; $display("FAIL R9/R6 addr act=%h exp=%h t=%0t", flash_addr, exp_a, $time);
         end
      end
   end

   int n_chk = 0, n_fail = 0;
   bit wd_fired = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // one bus cycle: 4 core cycles high, 4 low
   task automatic bus_cycle(input logic [15:0] a, input logic rnw, input logic [7:0] d,
                            input logic oe_n);
      host_addr = a; host_rnw = rnw; host_data = d; slot_oe_n = oe_n; slot_phi = 1'b1;
      step(4);
      slot_phi = 1'b0;
      step(4);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_chk + auto_chk + (wd_fired ? 1 : 0), n_fail + auto_fail + (wd_fired ? 1 : 0));
   endtask

   initial begin
      #200000;
      wd_fired = 1;
      $display("FAIL watchdog expired act=1 exp=0");
      summary();
      $finish;
   end

   initial begin
      step(3);
      @(negedge clk);
      check(flash_addr[16:15] == 2'd0, "R5 page in reset", flash_addr[16:15], 0);
      rst_n = 1'b1;
      step(2);
      @(negedge clk);
      check(flash_addr === 17'h0, "R5 page after reset", flash_addr, 0);
      check(flash_ce_n == 1'b1, "R4 ce idle low phase", flash_ce_n, 1);

      // R6 write page 2
      host_addr = 16'hFC80; host_rnw = 0; host_data = 8'h02; slot_oe_n = 1; slot_phi = 1;
      step(4);
      @(negedge clk);
      check(flash_addr[16:15] == 2'd0, "R6 not before falling edge", flash_addr[16:15], 0);
      step(0);
      slot_phi = 0;
      step(1);
      @(negedge clk);
      check(flash_addr[16:15] == 2'd2, "R6 load at fall", flash_addr[16:15], 2);
      step(3);

      // R1 read in window, R9 mapping
      host_addr = 16'hA5C3; host_rnw = 1; slot_oe_n = 0; slot_phi = 1;
      step(2);
      @(negedge clk);
      check(flash_ce_n == 0, "R1 ce high phase", flash_ce_n, 0);
      check(flash_oe_n == 0 && flash_we_n == 1, "R2 read strobes", {flash_oe_n, flash_we_n}, 1);
      check(flash_addr == {2'd2, 1'b0, 14'h25C3}, "R9 addr map", flash_addr, {2'd2, 1'b0, 14'h25C3});
      step(0);
      slot_phi = 0;
      step(1);
      @(negedge clk);
      check(flash_ce_n == 1, "R4 ce low phase oe_n low", flash_ce_n, 1);
      slot_oe_n = 1; step(1);
      slot_oe_n = 0; step(1);
      @(negedge clk);
      check(flash_ce_n == 1, "R4 ce after glitch low phase", flash_ce_n, 1);
      step(1);

      // R3 write strobes
      host_rnw = 0; slot_phi = 1; host_addr = 16'h8000;
      step(1);
      @(negedge clk);
      check(flash_we_n == 0 && flash_oe_n == 1, "R3 write strobes", {flash_we_n, flash_oe_n}, 1);
      step(2);
      slot_phi = 0; step(4);
      @(negedge clk);
      check(flash_addr[16:15] == 2'd2, "R7 other address write", flash_addr[16:15], 2);

      // R7 read of register address
      bus_cycle(16'hFC80, 1'b1, 8'h01, 1'b1);
      @(negedge clk);
      check(flash_addr[16:15] == 2'd2, "R7 read at reg addr", flash_addr[16:15], 2);
      bus_cycle(16'hFC81, 1'b0, 8'h01, 1'b1);
      @(negedge clk);
      check(flash_addr[16:15] == 2'd2, "R7 near address", flash_addr[16:15], 2);

      // R10 data changing in high phase: last value wins
      host_addr = 16'hFC80; host_rnw = 0; host_data = 8'h01; slot_phi = 1;
      step(2);
      host_data = 8'hFB; // low bits 3
      step(2);
      slot_phi = 0;
      step(4);
      @(negedge clk);
      check(flash_addr[16:15] == 2'd3, "R10 late data stored", flash_addr[16:15], 3);

      // R8 persistence over many cycles
      for (int i = 0; i < 20; i++) bus_cycle(16'h8000 + 16'(i * 97), 1'(i % 2), 8'(i), 1'(i % 3 == 0));
      @(negedge clk);
      check(flash_addr[16:15] == 2'd3, "R8 persists", flash_addr[16:15], 3);

      bus_cycle(16'hFC80, 1'b0, 8'h00, 1'b0);
      @(negedge clk);
      check(flash_addr[16:15] == 2'd0, "R6 load zero", flash_addr[16:15], 0);
      bus_cycle(16'hFC80, 1'b0, 8'h05, 1'b1);
      @(negedge clk);
      check(flash_addr[16:15] == 2'd1, "R6 load one", flash_addr[16:15], 1);

      // R5 reset mid-run
      rst_n = 0; step(2);
      @(negedge clk);
      check(flash_addr[16:15] == 2'd0, "R5 reset clears", flash_addr[16:15], 0);
      rst_n = 1; step(4);

      summary();
      $finish;
   end

endmodule